// File: doc/BRIEF.md
# Immediate-Folding Register Rename Stage

This block renames a group of decoded micro-ops. Each architectural register maps to a physical tag plus a small signed pending offset. An add of a small constant to a register only changes that register's mapping. The same holds for a copy of a register plus a small constant. Neither form emits an execution micro-op, so a chain of constant adds uses no ALU slot and adds no latency. Register-register operations are renamed normally. When such an operation reads a register whose offset is nonzero, the block first emits a materialize add. That add writes the tag plus the offset into a fresh register.

Up to `LANES` micro-ops arrive together. They are processed in program order inside one cycle, so a later lane sees every mapping change made by earlier lanes. Fresh tags come from a free-list pop port. If that port cannot cover the whole group, the group waits and nothing changes. Renamed entries are held in one output register. A two-state controller runs that register:
- ST_EMPTY: no entry is held.
- ST_HOLD: an entry is held for a valid/ready consumer.
- Transition ST_EMPTY to ST_HOLD: a group that emits at least one entry is loaded.
- Transition ST_HOLD to ST_HOLD: the consumer stalls, or a new emitting group replaces the drained one.
- Transition ST_HOLD to ST_EMPTY: the entry drains and no emitting group replaces it.

Top module: `imm_fold_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i with offset zero.
- R2: An add-immediate is folded when two conditions hold. The immediate must lie in -1024..1023, and the new offset must lie in -4096..4095. A folded add uses no output slot and pops no free tag. Its destination takes the source tag and the summed offset. Input kind encoding: 0 = add-immediate (source is the destination), 1 = copy-plus-immediate (source is src1), 2 or 3 = register-register ALU op.
- R3: An add-immediate whose immediate lies outside -1024..1023 emits an entry of kind 1. That entry has a fresh destination tag, the source tag, and the immediate equal to the old offset plus the immediate. The destination then has offset zero.
- R4: An add-immediate whose new offset would leave -4096..4095 is not folded and is emitted as in R3.
- R5: A copy-plus-immediate is folded under the R2 ranges. Its destination shares the source's tag and gets the source offset plus the immediate.
- R6: An ALU op emits a materialize entry (kind 0) for each source whose offset is nonzero. The entry's immediate is that offset. The source then maps to the fresh tag with offset zero. Slot 3l holds the src1 materialize of lane l and slot 3l+1 holds the src2 one. When both sources are the same register, only one materialize is emitted.
- R7: An ALU op emits an entry of kind 2 in slot 3l+2, after any materializes. It carries a fresh destination tag and the current source tags, and leaves its destination at offset zero.
- R8: Lane l uses the mappings left by lanes 0..l-1 of the same group.
- R9: Fresh tags are taken in increasing slot order, starting at free_tags[0]. On an accepted group, free_pop equals the number of tags used; otherwise it is 0.
- R10: When the group needs more tags than free_count, in_ready is low and neither the mappings nor the output change.
- R11: While out_valid is high and out_ready low, the held entries stay unchanged and in_ready is low. A group with no emitted entry leaves out_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Group accepted this cycle when in_valid is high |
| in_lane_vld | input | LANES | Per-lane micro-op present |
| in_kind | input | LANES x 2 | Per-lane operation kind |
| in_dst | input | LANES x AW | Destination architectural register |
| in_src1 | input | LANES x AW | First source architectural register |
| in_src2 | input | LANES x AW | Second source architectural register |
| in_imm | input | LANES x IMMW | Signed immediate |
| free_count | input | CW | Number of valid tags on free_tags |
| free_tags | input | NSLOT x TW | Tags available for allocation, in order |
| free_pop | output | CW | Tags consumed this cycle |
| out_valid | output | 1 | Held entries valid |
| out_ready | input | 1 | Consumer takes the held entries |
| out_slot_vld | output | NSLOT | Per-slot entry valid |
| out_kind | output | NSLOT x 2 | 0 materialize, 1 add-immediate, 2 ALU |
| out_dst | output | NSLOT x TW | Destination physical tag |
| out_src1 | output | NSLOT x TW | First source physical tag |
| out_src2 | output | NSLOT x TW | Second source physical tag (0 unless ALU) |
| out_imm | output | NSLOT x OIW | Signed immediate of the entry |

## Verification
A wrong pending offset stays hidden as long as only folded adds touch the register. It shows at the ports at the first later ALU read of that register, as a wrong materialize immediate, or as a materialize that should not be there, on the cycle after the group is accepted. A wrong tag mapping shows in the source tags of the next emitted entry that reads the register. A wrong allocation count shows at once on free_pop and on the in_ready decision for the same group. The reference model tracks the mappings, so every emitted entry, and every cycle's ready and pop values, are compared the moment they appear.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
    localparam int NARCH   = 8;
    localparam int NPHYS   = 64;
    localparam int LANES   = 6;
    localparam int IMMW    = 16;
    localparam int OFFW    = 13;
    localparam int IMM_LIM = 1024;
    localparam int OFF_LIM = 4096;

    localparam int AW    = $clog2(NARCH);
    localparam int TW    = $clog2(NPHYS);
    localparam int SPL   = 3;
    localparam int NSLOT = LANES * SPL;
    localparam int CW    = $clog2(NSLOT + 1);
    localparam int OIW   = IMMW + 2;

    localparam logic signed [IMMW-1:0] IMM_LO = IMMW'(-IMM_LIM);
    localparam logic signed [IMMW-1:0] IMM_HI = IMMW'(IMM_LIM - 1);
    localparam logic signed [OIW-1:0]  OFF_LO = OIW'(-OFF_LIM);
    localparam logic signed [OIW-1:0]  OFF_HI = OIW'(OFF_LIM - 1);

    // input operation kinds
    localparam logic [1:0] KI_ADDI  = 2'd0;
    localparam logic [1:0] KI_COPYI = 2'd1;
    // output entry kinds
    localparam logic [1:0] KO_MAT = 2'd0;
    localparam logic [1:0] KO_ADD = 2'd1;
    localparam logic [1:0] KO_ALU = 2'd2;

    typedef struct packed {
        logic [TW-1:0]   tag;
        logic [OFFW-1:0] off;
    } map_ent_t;

    typedef map_ent_t [NARCH-1:0] map_vec_t;

    typedef struct packed {
        logic            vld;
        logic [1:0]      kind;
        logic [TW-1:0]   dst;
        logic [TW-1:0]   s1;
        logic [TW-1:0]   s2;
        logic [OIW-1:0]  imm;
    } slot_t;

    typedef enum logic {ST_EMPTY, ST_HOLD} ost_e;

    function automatic logic [OIW-1:0] off_ext(input logic [OFFW-1:0] o);
        return {{(OIW-OFFW){o[OFFW-1]}}, o};
    endfunction
endpackage

// File: rtl/ifr_map_table.sv
module ifr_map_table
    import ifr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  map_vec_t map_next,
    output map_vec_t map_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++) begin
                map_q[i].tag <= TW'(i);
                map_q[i].off <= '0;
            end
        end else if (wr_en) begin
            map_q <= map_next;
        end
    end
endmodule

// File: rtl/ifr_lane.sv
module ifr_lane
    import ifr_pkg::*;
(
    input  logic                      lane_vld,
    input  logic [1:0]                kind,
    input  logic [AW-1:0]             dst,
    input  logic [AW-1:0]             src1,
    input  logic [AW-1:0]             src2,
    input  logic [IMMW-1:0]           imm,
    input  map_vec_t                  map_in,
    input  logic [CW-1:0]             alloc_in,
    input  logic [NSLOT-1:0][TW-1:0]  free_tags,
    output map_vec_t                  map_out,
    output slot_t [SPL-1:0]           slots,
    output logic [CW-1:0]             alloc_out
);
    logic [AW-1:0]          src_sel;
    map_ent_t               ent;
    logic signed [OIW-1:0]  imm_x;
    logic signed [OIW-1:0]  sum;
    logic                   imm_ok;
    logic                   sum_ok;
    logic                   is_imm_op;

    always_comb begin
        is_imm_op = (kind == KI_ADDI) || (kind == KI_COPYI);
        src_sel   = (kind == KI_ADDI) ? dst : src1;
        ent       = map_in[src_sel];
        imm_x     = {{(OIW-IMMW){imm[IMMW-1]}}, imm};
        sum       = $signed(off_ext(ent.off)) + imm_x;
        imm_ok    = ($signed(imm) >= IMM_LO) && ($signed(imm) <= IMM_HI);
        sum_ok    = (sum >= OFF_LO) && (sum <= OFF_HI);
    end

    always_comb begin
        map_out   = map_in;
        alloc_out = alloc_in;
        slots     = '0;
        if (lane_vld) begin
            if (is_imm_op) begin
                if (imm_ok && sum_ok) begin
                    // folded: mapping only
                    map_out[dst].tag = ent.tag;
                    map_out[dst].off = sum[OFFW-1:0];
                end else begin
                    slots[2].vld  = 1'b1;
                    slots[2].kind = KO_ADD;
                    slots[2].dst  = free_tags[alloc_out];
                    slots[2].s1   = ent.tag;
                    slots[2].s2   = TW'(0);
                    slots[2].imm  = sum;
                    map_out[dst].tag = free_tags[alloc_out];
                    map_out[dst].off = '0;
                    alloc_out = alloc_out + CW'(1);
                end
            end else begin
                if (map_out[src1].off != '0) begin
                    slots[0].vld  = 1'b1;
                    slots[0].kind = KO_MAT;
                    slots[0].dst  = free_tags[alloc_out];
                    slots[0].s1   = map_out[src1].tag;
                    slots[0].s2   = TW'(0);
                    slots[0].imm  = off_ext(map_out[src1].off);
                    map_out[src1].tag = free_tags[alloc_out];
                    map_out[src1].off = '0;
                    alloc_out = alloc_out + CW'(1);
                end
                if (map_out[src2].off != '0) begin
                    slots[1].vld  = 1'b1;
                    slots[1].kind = KO_MAT;
                    slots[1].dst  = free_tags[alloc_out];
                    slots[1].s1   = map_out[src2].tag;
                    slots[1].s2   = TW'(0);
                    slots[1].imm  = off_ext(map_out[src2].off);
                    map_out[src2].tag = free_tags[alloc_out];
                    map_out[src2].off = '0;
                    alloc_out = alloc_out + CW'(1);
                end
                slots[2].vld  = 1'b1;
                slots[2].kind = KO_ALU;
                slots[2].dst  = free_tags[alloc_out];
                slots[2].s1   = map_out[src1].tag;
                slots[2].s2   = map_out[src2].tag;
                slots[2].imm  = '0;
                map_out[dst].tag = free_tags[alloc_out];
                map_out[dst].off = '0;
                alloc_out = alloc_out + CW'(1);
            end
        end
    end
endmodule

// File: rtl/ifr_out_stage.sv
module ifr_out_stage
    import ifr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  slot_t [NSLOT-1:0]   slots_in,
    input  logic                out_ready,
    output logic                can_take,
    output logic                out_valid,
    output slot_t [NSLOT-1:0]   slots_q
);
    ost_e state, state_nx;
    logic any_emit;

    always_comb begin
        any_emit = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            any_emit = any_emit | slots_in[s].vld;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                if (load && any_emit) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (load)           state_nx = any_emit ? ST_HOLD : ST_EMPTY;
                else if (out_ready) state_nx = ST_EMPTY;
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    always_comb begin
        out_valid = (state == ST_HOLD);
        can_take  = (state == ST_EMPTY) || out_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
        end else if (load) begin
            slots_q <= slots_in;
        end
    end
endmodule

// File: rtl/imm_fold_rename.sv
module imm_fold_rename
    import ifr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [LANES-1:0]            in_lane_vld,
    input  logic [LANES-1:0][1:0]       in_kind,
    input  logic [LANES-1:0][AW-1:0]    in_dst,
    input  logic [LANES-1:0][AW-1:0]    in_src1,
    input  logic [LANES-1:0][AW-1:0]    in_src2,
    input  logic [LANES-1:0][IMMW-1:0]  in_imm,
    input  logic [CW-1:0]               free_count,
    input  logic [NSLOT-1:0][TW-1:0]    free_tags,
    output logic [CW-1:0]               free_pop,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [NSLOT-1:0]            out_slot_vld,
    output logic [NSLOT-1:0][1:0]       out_kind,
    output logic [NSLOT-1:0][TW-1:0]    out_dst,
    output logic [NSLOT-1:0][TW-1:0]    out_src1,
    output logic [NSLOT-1:0][TW-1:0]    out_src2,
    output logic [NSLOT-1:0][OIW-1:0]   out_imm
);
    map_vec_t           map_q;
    map_vec_t           map_chain   [LANES+1];
    logic [CW-1:0]      alloc_chain [LANES+1];
    slot_t [NSLOT-1:0]  slots_c;
    slot_t [NSLOT-1:0]  slots_q;
    logic [CW-1:0]      need;
    logic               can_take;
    logic               accept;

    ifr_map_table u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .map_next (map_chain[LANES]),
        .map_q    (map_q)
    );

    assign map_chain[0]   = map_q;
    assign alloc_chain[0] = '0;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ifr_lane u_lane (
            .lane_vld  (in_lane_vld[l]),
            .kind      (in_kind[l]),
            .dst       (in_dst[l]),
            .src1      (in_src1[l]),
            .src2      (in_src2[l]),
            .imm       (in_imm[l]),
            .map_in    (map_chain[l]),
            .alloc_in  (alloc_chain[l]),
            .free_tags (free_tags),
            .map_out   (map_chain[l+1]),
            .slots     (slots_c[l*SPL +: SPL]),
            .alloc_out (alloc_chain[l+1])
        );
    end

    assign need     = alloc_chain[LANES];
    assign in_ready = rst_n && can_take && (need <= free_count);
    assign accept   = in_valid && in_ready;
    assign free_pop = accept ? need : '0;

    ifr_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .slots_in  (slots_c),
        .out_ready (out_ready),
        .can_take  (can_take),
        .out_valid (out_valid),
        .slots_q   (slots_q)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_unpack
        assign out_slot_vld[s] = slots_q[s].vld;
        assign out_kind[s]     = slots_q[s].kind;
        assign out_dst[s]      = slots_q[s].dst;
        assign out_src1[s]     = slots_q[s].s1;
        assign out_src2[s]     = slots_q[s].s2;
        assign out_imm[s]      = slots_q[s].imm;
    end
endmodule

// File: rtl/ifr_checker.sv
module ifr_checker
    import ifr_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [CW-1:0]              free_count,
    input logic [CW-1:0]              free_pop,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [NSLOT-1:0]           out_slot_vld,
    input logic [NSLOT-1:0][1:0]      out_kind,
    input logic [NSLOT-1:0][TW-1:0]   out_dst,
    input logic [NSLOT-1:0][OIW-1:0]  out_imm
);
    AST_POP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (free_pop != '0) |-> (in_valid && in_ready)); // R9

    AST_POP_MATCHES_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(free_pop) != '0) |-> (out_valid && ($countones(out_slot_vld) == int'($past(free_pop))))); // R9

    AST_POP_WITHIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        free_pop <= free_count); // R10

    AST_BLOCKED_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R11

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_slot_vld) && $stable(out_dst) && $stable(out_imm))); // R11

    AST_VALID_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slot_vld != '0)); // R11

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if ((s % SPL) != (SPL - 1)) begin : g_mat
            AST_MAT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_slot_vld[s]) |-> ((out_kind[s] == KO_MAT) && (out_imm[s] != '0))); // R6
            AST_MAT_FEEDS_ALU: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_slot_vld[s]) |-> (out_slot_vld[s - (s % SPL) + SPL - 1] && (out_kind[s - (s % SPL) + SPL - 1] == KO_ALU))); // R7
        end else begin : g_main
            AST_MAIN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_slot_vld[s]) |-> (out_kind[s] != KO_MAT)); // R6
        end
    end
endmodule

bind imm_fold_rename ifr_checker i_chk (.*);

// File: tb/test_imm_fold_rename.sv
`timescale 1ns/100ps
module test_imm_fold_rename;
    import ifr_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst_n;
    logic                        in_valid;
    logic                        in_ready;
    logic [LANES-1:0]            in_lane_vld;
    logic [LANES-1:0][1:0]       in_kind;
    logic [LANES-1:0][AW-1:0]    in_dst;
    logic [LANES-1:0][AW-1:0]    in_src1;
    logic [LANES-1:0][AW-1:0]    in_src2;
    logic [LANES-1:0][IMMW-1:0]  in_imm;
    logic [CW-1:0]               free_count;
    logic [NSLOT-1:0][TW-1:0]    free_tags;
    logic [CW-1:0]               free_pop;
    logic                        out_valid;
    logic                        out_ready;
    logic [NSLOT-1:0]            out_slot_vld;
    logic [NSLOT-1:0][1:0]       out_kind;
    logic [NSLOT-1:0][TW-1:0]    out_dst;
    logic [NSLOT-1:0][TW-1:0]    out_src1;
    logic [NSLOT-1:0][TW-1:0]    out_src2;
    logic [NSLOT-1:0][OIW-1:0]   out_imm;

    imm_fold_rename i_imm_fold_rename (.*);

    always #2.5 clk = ~clk;

    // stimulus and model state
    int lv [LANES]; int lk [LANES]; int ld [LANES];
    int ls1 [LANES]; int ls2 [LANES]; int li [LANES];
    int rt [NARCH]; int ro [NARCH]; int nt [NARCH]; int no [NARCH];
    int es_v [NSLOT]; int es_k [NSLOT]; int es_d [NSLOT];
    int es_1 [NSLOT]; int es_2 [NSLOT]; int es_i [NSLOT];
    int ms_v [NSLOT]; int ms_k [NSLOT]; int ms_d [NSLOT];
    int ms_1 [NSLOT]; int ms_2 [NSLOT]; int ms_i [NSLOT];
    int m_ov;
    int base;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic int ftag(int k);
        return (base + k) % (NPHYS - NARCH) + NARCH;
    endfunction

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic clear_group();
        for (int l = 0; l < LANES; l++) begin
            lv[l] = 0; lk[l] = 0; ld[l] = 0; ls1[l] = 0; ls2[l] = 0; li[l] = 0;
        end
    endtask

    task automatic setl(int l, int k, int d, int a, int b, int imm);
        lv[l] = 1; lk[l] = k; ld[l] = d; ls1[l] = a; ls2[l] = b; li[l] = imm;
    endtask

    task automatic apply();
        for (int l = 0; l < LANES; l++) begin
            in_lane_vld[l] = (lv[l] != 0);
            in_kind[l]     = 2'(lk[l]);
            in_dst[l]      = AW'(ld[l]);
            in_src1[l]     = AW'(ls1[l]);
            in_src2[l]     = AW'(ls2[l]);
            in_imm[l]      = IMMW'(li[l]);
        end
        for (int k = 0; k < NSLOT; k++) free_tags[k] = TW'(ftag(k));
    endtask

    task automatic emit(int s, int k, int d, int a, int b, int imm);
        es_v[s] = 1; es_k[s] = k; es_d[s] = d; es_1[s] = a; es_2[s] = b; es_i[s] = imm;
    endtask

    // behavioural renaming of the current group, lanes in order (R8)
    task automatic model_group(output int need);
        int a = 0;
        for (int r = 0; r < NARCH; r++) begin nt[r] = rt[r]; no[r] = ro[r]; end
        for (int s = 0; s < NSLOT; s++) begin
            es_v[s] = 0; es_k[s] = 0; es_d[s] = 0; es_1[s] = 0; es_2[s] = 0; es_i[s] = 0;
        end
        for (int l = 0; l < LANES; l++) begin
            if (lv[l] == 0) continue;
            if (lk[l] == 0 || lk[l] == 1) begin
                int src = (lk[l] == 0) ? ld[l] : ls1[l];
                int sum = no[src] + li[l];
                int stag = nt[src];
                if (li[l] >= -1024 && li[l] <= 1023 && sum >= -4096 && sum <= 4095) begin
                    nt[ld[l]] = stag; no[ld[l]] = sum;
                end else begin
                    emit(3*l+2, 1, ftag(a), stag, 0, sum);
                    nt[ld[l]] = ftag(a); no[ld[l]] = 0; a++;
                end
            end else begin
                if (no[ls1[l]] != 0) begin
                    emit(3*l, 0, ftag(a), nt[ls1[l]], 0, no[ls1[l]]);
                    nt[ls1[l]] = ftag(a); no[ls1[l]] = 0; a++;
                end
                if (no[ls2[l]] != 0) begin
                    emit(3*l+1, 0, ftag(a), nt[ls2[l]], 0, no[ls2[l]]);
                    nt[ls2[l]] = ftag(a); no[ls2[l]] = 0; a++;
                end
                emit(3*l+2, 2, ftag(a), nt[ls1[l]], nt[ls2[l]], 0);
                nt[ld[l]] = ftag(a); no[ld[l]] = 0; a++;
            end
        end
        need = a;
    endtask

    // one clock: inputs set at negedge, compared before and after the edge
    task automatic step(string req);
        int need;
        int rdy;
        int acc;
        int any;
        apply();
        #1;
        model_group(need);
        rdy = ((m_ov == 0 || out_ready) && need <= int'(free_count)) ? 1 : 0;
        acc = (in_valid && rdy != 0) ? 1 : 0;
        chk({req, " in_ready (R10/R11)"}, int'(in_ready), rdy);
        chk({req, " free_pop (R9)"}, int'(free_pop), acc ? need : 0);
        @(posedge clk);
        if (acc != 0) begin
            any = 0;
            for (int r = 0; r < NARCH; r++) begin rt[r] = nt[r]; ro[r] = no[r]; end
            for (int s = 0; s < NSLOT; s++) begin
                ms_v[s] = es_v[s]; ms_k[s] = es_k[s]; ms_d[s] = es_d[s];
                ms_1[s] = es_1[s]; ms_2[s] = es_2[s]; ms_i[s] = es_i[s];
                if (es_v[s] != 0) any = 1;
            end
            m_ov = any;
            base = base + need;
        end else if (out_ready) begin
            m_ov = 0;
        end
        @(negedge clk);
        chk({req, " out_valid (R11)"}, int'(out_valid), m_ov);
        if (m_ov != 0) begin
            for (int s = 0; s < NSLOT; s++) begin
                chk({req, $sformatf(" slot%0d vld", s)}, int'(out_slot_vld[s]), ms_v[s]);
                if (ms_v[s] != 0) begin
                    chk({req, $sformatf(" slot%0d kind", s)}, int'(out_kind[s]), ms_k[s]);
                    chk({req, $sformatf(" slot%0d dst", s)}, int'(out_dst[s]), ms_d[s]);
                    chk({req, $sformatf(" slot%0d src1", s)}, int'(out_src1[s]), ms_1[s]);
                    chk({req, $sformatf(" slot%0d src2", s)}, int'(out_src2[s]), ms_2[s]);
                    chk({req, $sformatf(" slot%0d imm", s)}, int'($signed(out_imm[s])), ms_i[s]);
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=completion");
        errors++;
        checks++;
        finish_up();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; free_count = CW'(NSLOT);
        base = 0; m_ov = 0;
        for (int r = 0; r < NARCH; r++) begin rt[r] = r; ro[r] = 0; end
        clear_group();
        apply();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset out_valid", int'(out_valid), 0);
        step("R11 idle");

        // R1: untouched registers read their own index as tag
        clear_group(); setl(0, 2, 1, 2, 3, 0); in_valid = 1'b1;
        step("R1 identity map");

        // R2 R8: six folded +1 on r0, nothing emitted, nothing popped
        clear_group();
        for (int l = 0; l < LANES; l++) setl(l, 0, 0, 0, 0, 1);
        step("R2 fold chain");
        // R6: r0 read twice, one materialize with offset 6
        clear_group(); setl(0, 2, 4, 0, 0, 0);
        step("R6 same source");

        // R3: +1024 emitted, -1024 and +1023 folded on the result
        clear_group(); setl(0, 0, 5, 0, 0, 1024); setl(1, 0, 5, 0, 0, -1024);
        setl(2, 0, 5, 0, 0, 1023); setl(3, 2, 0, 5, 1, 0);
        step("R3 imm range");

        // R4: offset climbs to 4095, then +1 leaves the range
        clear_group();
        for (int l = 0; l < 4; l++) setl(l, 0, 6, 0, 0, 1023);
        setl(4, 0, 6, 0, 0, 3); setl(5, 0, 6, 0, 0, 1);
        step("R4 offset high");
        clear_group();
        for (int l = 0; l < 4; l++) setl(l, 0, 7, 0, 0, -1024);
        setl(4, 0, 7, 0, 0, -1); setl(5, 2, 1, 7, 2, 0);
        step("R4 offset low");

        // R5 R6 R8: copies share a tag, consumer materializes both
        clear_group(); setl(0, 1, 3, 4, 0, 5); setl(1, 1, 5, 3, 0, 2);
        setl(2, 2, 6, 3, 5, 0); setl(3, 0, 6, 0, 0, 9); setl(4, 2, 2, 6, 6, 0);
        step("R5 copy fold");

        // R10: not enough tags, group waits unchanged
        clear_group(); setl(0, 1, 1, 2, 0, 7); setl(1, 2, 0, 1, 1, 0);
        free_count = CW'(1);
        step("R10 stall");
        step("R10 stall repeat");
        free_count = CW'(2);
        step("R10 exact fit");
        free_count = CW'(NSLOT);

        // R11: downstream blocks, held entries stay
        clear_group(); setl(0, 2, 3, 1, 2, 0); out_ready = 1'b0;
        step("R11 load");
        clear_group(); setl(0, 2, 4, 3, 3, 0);
        step("R11 hold");
        step("R11 hold again");
        out_ready = 1'b1;
        step("R11 drain reload");
        clear_group(); setl(0, 0, 2, 0, 0, 4);
        step("R11 empty group");
        in_valid = 1'b0;
        step("R11 idle after");

        // mixed traffic covering R2-R11
        for (int it = 0; it < 400; it++) begin
            in_valid   = ($urandom % 4) != 0;
            out_ready  = ($urandom % 4) != 0;
            free_count = (($urandom % 5) == 0) ? CW'($urandom % NSLOT) : CW'(NSLOT);
            clear_group();
            for (int l = 0; l < LANES; l++) begin
                int sel = int'($urandom % 4);
                int imm;
                if (sel == 0)      imm = int'($urandom % 16) - 8;
                else if (sel == 1) imm = 1018 + int'($urandom % 10);
                else if (sel == 2) imm = -1030 + int'($urandom % 10);
                else               imm = int'($urandom % 60000) - 30000;
                if (($urandom % 6) != 0)
                    setl(l, int'($urandom % 4), int'($urandom % NARCH),
                         int'($urandom % NARCH), int'($urandom % NARCH), imm);
            end
            step("R8 mixed");
        end
        finish_up();
    end
endmodule